// File: doc/BRIEF.md
# Time-Multiplexed NOR2 Logic Evaluator

This block evaluates an arbitrary combinational netlist using only one two-input NOR element. It reuses that element once per clock for every gate in the netlist. A 64-entry bit store holds the primary inputs and one slot for each gate's result. An instruction store holds one word per gate. Each word names two source slots and one destination slot. On each step, the block reads both sources, NORs them, and writes the result to the destination. The written value is visible to the next step, so the bit store also carries values from one gate to the next.

Software first loads the program, the program length and the input bits through the loader strobes. It then pulses `start` and waits for the one-cycle `done` pulse. After that it reads any slot through the read port. The program must already be in topological order: every gate comes after the gates that feed it. Each `start` runs the program from instruction 0.

Top module: `nor_seq_eval`

## Requirements
- R1: After reset, `busy` and `done` are low, and every data slot reads 0 on `rd_data`.
- R2: While idle, a data strobe (`ld_dwe`) stores `ld_dbit` into slot `ld_daddr`. The new value is readable on `rd_data` in the following cycle.
- R3: An instruction word is 18 bits. Bits [17:12] are source A, bits [11:6] are source B, and bits [5:0] are the destination. Executing it stores NOR(slot A, slot B) into the destination slot.
- R4: One instruction completes per clock. A result written by one instruction is the value read by the next instruction. A chain of dependent gates therefore evaluates correctly with no gaps.
- R5: When `start` is sampled while idle and the length is N>0, `busy` is high for exactly N cycles. `done` is then high for exactly one cycle, in the cycle after `busy` falls.
- R6: `start` is ignored while `busy` is high. No second run follows the current one.
- R7: Loader writes (data slot, instruction and length) are ignored while `busy` is high.
- R8: Starting with a length of 0 raises `busy` for no cycle. It gives a single `done` pulse in the cycle after `start` is sampled, and leaves the data unchanged.
- R9: Every run begins at instruction 0. A later run with a different length re-executes the program from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_iwe | input | 1 | Instruction write strobe |
| ld_iaddr | input | 6 | Instruction index to write |
| ld_iword | input | 18 | Instruction word {srcA, srcB, dst} |
| ld_dwe | input | 1 | Data slot write strobe |
| ld_daddr | input | 6 | Data slot to write |
| ld_dbit | input | 1 | Bit value to write |
| ld_lwe | input | 1 | Program length write strobe |
| ld_len | input | 7 | Number of instructions to run (0 to 64) |
| start | input | 1 | Begin a run (sampled when idle) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the last instruction |
| rd_addr | input | 6 | Slot to read |
| rd_data | output | 1 | Current value of slot `rd_addr` |

## Verification
The bench drives inputs and samples outputs on the falling edge. A loader write is visible on `rd_data` at the next falling edge. After `start` is sampled, `busy` reads high at the next falling edge. It is counted over the falling edges until it drops, and that count must equal the length. `done` must read high at the falling edge where `busy` first reads low, and low one edge later. Results are read only after `done`, because each gate's slot settles one edge after its own step. The XOR2 and XOR3 results are compared against a vector table that covers every input combination.

// File: rtl/nor_seq_eval.sv
module nor_seq_eval #(
  parameter int AW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_iwe,
  input  logic [AW-1:0]   ld_iaddr,
  input  logic [3*AW-1:0] ld_iword,
  input  logic            ld_dwe,
  input  logic [AW-1:0]   ld_daddr,
  input  logic            ld_dbit,
  input  logic            ld_lwe,
  input  logic [AW:0]     ld_len,
  input  logic            start,
  output logic            busy,
  output logic            done,
  input  logic [AW-1:0]   rd_addr,
  output logic            rd_data
);
  localparam int DEPTH = 1 << AW;
  localparam int IW    = 3 * AW;

  logic [DEPTH-1:0] slots;
  logic [IW-1:0]    imem [DEPTH];
  logic [AW-1:0]    pc;
  logic [AW:0]      len_q;

  logic [IW-1:0] cur;
  logic [AW-1:0] src_a, src_b, dst;
  logic          nor_out, last, idle_go;

  assign cur     = imem[pc];
  assign src_a   = cur[3*AW-1:2*AW];
  assign src_b   = cur[2*AW-1:AW];
  assign dst     = cur[AW-1:0];
  assign nor_out = ~(slots[src_a] | slots[src_b]);
  assign last    = ({1'b0, pc} == len_q - 1'b1);
  assign idle_go = start && !busy;
  assign rd_data = slots[rd_addr];

  always_ff @(posedge clk)
    if (ld_iwe && !busy) imem[ld_iaddr] <= ld_iword;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slots <= '0;
      pc    <= '0;
      len_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        slots[dst] <= nor_out;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          pc   <= '0;
        end else begin
          pc <= pc + 1'b1;
        end
      end else begin
        if (ld_dwe) slots[ld_daddr] <= ld_dbit;
        if (ld_lwe) len_q <= ld_len;
        if (idle_go) begin
          if (len_q == '0) done <= 1'b1;
          else             busy <= 1'b1;
        end
      end
    end
  end

  a_r5_done_follows_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) || $past(start && len_q == '0));
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_pc_steps: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> busy && pc == $past(pc) + 1'b1);
  a_r9_pc_home_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> pc == '0);
  a_r7_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(len_q));
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

// File: tb/nor_seq_eval_tb.sv
module nor_seq_eval_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic ld_iwe = 0, ld_dwe = 0, ld_lwe = 0, ld_dbit = 0, start = 0;
  logic [5:0] ld_iaddr = '0, ld_daddr = '0, rd_addr = '0;
  logic [17:0] ld_iword = '0;
  logic [6:0] ld_len = '0;
  logic busy, done, rd_data;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  nor_seq_eval u_dut (.clk, .rst_n, .ld_iwe, .ld_iaddr, .ld_iword, .ld_dwe,
    .ld_daddr, .ld_dbit, .ld_lwe, .ld_len, .start, .busy, .done, .rd_addr, .rd_data);

  // {a, b, c, a^b^c}
  localparam logic [3:0] VEC [8] = '{4'b0000, 4'b0011, 4'b0101, 4'b0110,
                                     4'b1001, 4'b1010, 4'b1100, 4'b1111};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put_instr(input int idx, input int a, input int b, input int d);
    @(negedge clk);
    ld_iwe = 1; ld_iaddr = 6'(idx); ld_iword = {6'(a), 6'(b), 6'(d)};
    @(negedge clk); ld_iwe = 0;
  endtask

  task automatic put_bit(input int s, input bit v);
    @(negedge clk);
    ld_dwe = 1; ld_daddr = 6'(s); ld_dbit = v;
    @(negedge clk); ld_dwe = 0;
  endtask

  task automatic set_len(input int n);
    @(negedge clk);
    ld_lwe = 1; ld_len = 7'(n);
    @(negedge clk); ld_lwe = 0;
  endtask

  function automatic bit peek_now(input int s);
    return 1'b0;
  endfunction

  task automatic read_slot(input int s, output bit v);
    @(negedge clk); rd_addr = 6'(s);
    #1 v = rd_data;
  endtask

  task automatic put_xor(input int x, input int y, input int g, input int i0);
    put_instr(i0,   x,   y,   g);
    put_instr(i0+1, x,   g,   g+1);
    put_instr(i0+2, y,   g,   g+2);
    put_instr(i0+3, g+1, g+2, g+3);
    put_instr(i0+4, g+3, g+3, g+4);
  endtask

  // R5: start, count busy cycles, check done pulse
  task automatic run(input int n, input string tag);
    int cnt = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (busy && cnt < 200) begin cnt++; @(negedge clk); end
    chk(cnt == n, {tag, " R5 busy cycles"}, cnt, n);
    chk(done == 1'b1, {tag, " R5 done pulse"}, done, 1);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R5 done width"}, done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit v;
    int nz;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    @(negedge clk);
    chk(!busy && !done, "R1 busy/done low", {busy, done}, 0);
    nz = 0;
    for (int s = 0; s < 64; s++) begin read_slot(s, v); nz += v; end
    chk(nz == 0, "R1 slots cleared", nz, 0);
    // R2
    put_bit(40, 1); read_slot(40, v);
    chk(v == 1, "R2 slot write", v, 1);
    put_bit(40, 0); read_slot(40, v);
    chk(v == 0, "R2 slot rewrite", v, 0);
    // program: XOR2(a,b)->slot 7, XOR3 -> slot 12 (R3 field layout)
    put_xor(0, 1, 3, 0);
    put_xor(7, 2, 8, 5);
    // R3/R4/R9: vector table walk
    for (int k = 0; k < 8; k++) begin
      put_bit(0, VEC[k][3]); put_bit(1, VEC[k][2]); put_bit(2, VEC[k][1]);
      set_len(5); run(5, "xor2");
      read_slot(7, v);
      chk(v == (VEC[k][3] ^ VEC[k][2]), "R3 R4 xor2 result", v, VEC[k][3] ^ VEC[k][2]);
      set_len(10); run(10, "xor3");
      read_slot(12, v);
      chk(v == VEC[k][0], "R4 R9 xor3 result", v, VEC[k][0]);
    end
    // R3 single instruction with distinct sources: nor(1,0)=0
    put_bit(20, 1); put_bit(21, 0); put_bit(22, 1);
    put_instr(0, 20, 21, 22); set_len(1); run(1, "single");
    read_slot(22, v);
    chk(v == 0, "R3 nor(1,0)", v, 0);
    put_bit(20, 0); run(1, "single2");
    read_slot(22, v);
    chk(v == 1, "R3 nor(0,0)", v, 1);
    // R6/R7: restore xor program, pulse start and loaders mid-run
    put_xor(0, 1, 3, 0);
    put_bit(0, 1); put_bit(1, 0); put_bit(2, 0);
    set_len(10);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    start = 1; ld_dwe = 1; ld_daddr = 6'd0; ld_dbit = 0; ld_lwe = 1; ld_len = 7'd3;
    ld_iwe = 1; ld_iaddr = 6'd9; ld_iword = {6'd0, 6'd0, 6'd12};
    @(negedge clk);
    start = 0; ld_dwe = 0; ld_lwe = 0; ld_iwe = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(!busy, "R6 no restart", busy, 0);
    read_slot(0, v);
    chk(v == 1, "R7 slot write ignored", v, 1);
    read_slot(12, v);
    chk(v == 1, "R7 instr write ignored", v, 1);
    run(10, "R7 len kept");
    // R8
    set_len(0);
    put_bit(12, 0);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(done && !busy, "R8 zero-length done", {done, busy}, 2);
    @(negedge clk);
    chk(!done && !busy, "R8 single pulse", {done, busy}, 0);
    read_slot(12, v);
    chk(v == 0, "R8 data unchanged", v, 0);
    v = peek_now(0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule